// File: doc/BRIEF.md
# Snooping MESI Cache Controller

This block keeps coherence state for a small direct-mapped cache that sits on a shared snooping bus. Each line holds a tag, a data line of several words and one of four coherence states: Invalid, Shared, Exclusive or Modified. The core sends one of four request kinds: a load of one word, a store of one word, a load-exclusive that fetches a line with ownership in advance of a write, and a write that replaces a whole line. The controller serves a request locally when the line's state allows. Otherwise it runs bus transactions one at a time and holds the core off until the last one completes.

On the bus the controller issues a read, a read-for-ownership, an invalidate, or a writeback of a dirty victim. When a read completes it samples a shared-response input to choose between Exclusive and Shared. The controller also watches transactions from other agents. On its snoop port it signals that it holds a copy, hands over dirty data when it holds the line Modified, and downgrades or drops its copy in the same clock edge.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snoop of any line address sees `snp_shared_o` low, and the first load to any address issues a bus read.
- R2: A load that misses issues a bus read (cmd 2'b01) on the line address `{tag, index}` and returns the addressed word of `bus_rdata_i`. The line is installed Exclusive if `bus_shared_i` is low at the acknowledge and Shared if it is high.
- R3: A store to a line held Exclusive or Modified makes the line Modified and issues no bus transaction.
- R4: A store to a line held Shared first issues an invalidate (cmd 2'b11) and then commits. A store that misses issues a read-for-ownership (cmd 2'b10) and merges the store word into the returned line. In both cases the line ends Modified.
- R5: A load-exclusive to a line that is Shared or missing issues a read-for-ownership and installs the line Exclusive whatever `bus_shared_i` says. On a line held Exclusive or Modified it is served locally.
- R6: A snooped read (cmd 2'b01) that hits a line sets `snp_shared_o`. Exclusive and Modified lines become Shared. A Modified line also raises `snp_flush_o` with the line on `snp_data_o`.
- R7: A snooped read-for-ownership or invalidate that hits a line sets `snp_shared_o` and makes the line Invalid. A Modified line raises `snp_flush_o` with its data first. A snooped writeback (cmd 2'b00) is ignored.
- R8: A full-line write to a line that is Shared or missing issues only an invalidate, with no data fetch, and installs `req_wline_i` as Modified. On an Exclusive or Modified line it is served locally.
- R9: A miss that replaces a Modified line first issues a writeback (cmd 2'b00) carrying the victim's address and data. Replacing an Exclusive or Shared line issues no writeback.
- R10: At most one bus transaction is outstanding. `bus_req_o` and its command and address stay stable until `bus_ack_i`. `req_ready_o` is a one-cycle pulse, given only after every transaction of the request has been acknowledged, and `rsp_rdata_o` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid, held until ready |
| req_ready_o | output | 1 | Request complete (one-cycle pulse) |
| req_op_i | input | 2 | 0 load, 1 store, 2 load-exclusive, 3 full-line write |
| req_addr_i | input | ADDR_W | Byte-free word address {tag, index, word offset} |
| req_wdata_i | input | WORD_W | Store word |
| req_wline_i | input | WORD_W*LINE_WORDS | Full-line write data |
| rsp_rdata_o | output | WORD_W | Addressed word of the line after the request |
| bus_req_o | output | 1 | Bus transaction request |
| bus_cmd_o | output | 2 | 0 writeback, 1 read, 2 read-for-ownership, 3 invalidate |
| bus_addr_o | output | ADDR_W-log2(LINE_WORDS) | Line address of the transaction |
| bus_wdata_o | output | WORD_W*LINE_WORDS | Writeback data |
| bus_ack_i | input | 1 | Transaction complete |
| bus_shared_i | input | 1 | Another agent holds the line (sampled with ack) |
| bus_rdata_i | input | WORD_W*LINE_WORDS | Line data returned with ack |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 2 | Snooped command, same codes as bus_cmd_o |
| snp_addr_i | input | ADDR_W-log2(LINE_WORDS) | Snooped line address |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_flush_o | output | 1 | Dirty data supplied on snp_data_o |
| snp_data_o | output | WORD_W*LINE_WORDS | Supplied line data |

## Verification
The bench builds the block with four lines, four 16-bit words per line and 8-bit addresses, which leaves a 4-bit tag. The random phase draws tags from only three values, so addresses alias onto the same index all the time. That makes evictions of Modified, Exclusive and Shared victims frequent, and it brings writeback-then-miss sequences and snoops against every state within reach of a few hundred requests. The bus responder returns random line data, random shared responses and random acknowledge latency.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} mesi_state_e;
  typedef enum logic [1:0] {BUS_WB = 2'b00, BUS_RD = 2'b01, BUS_RDX = 2'b10, BUS_INV = 2'b11} bus_cmd_e;
  typedef enum logic [1:0] {OP_LOAD = 2'b00, OP_STORE = 2'b01, OP_LDEX = 2'b10, OP_FULLWR = 2'b11} core_op_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 8,
  parameter int LINE_W    = 128,
  parameter int IDX_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  sp_idx_i,
  input  logic              fsm_we_i,
  input  mesi_state_e       fsm_state_i,
  input  logic [TAG_W-1:0]  fsm_tag_i,
  input  logic [LINE_W-1:0] fsm_data_i,
  input  logic              sp_we_i,
  input  mesi_state_e       sp_state_i,
  output mesi_state_e       rd_state_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o,
  output mesi_state_e       sp_state_o,
  output logic [TAG_W-1:0]  sp_tag_o,
  output logic [LINE_W-1:0] sp_data_o
);
  mesi_state_e       st_arr  [NUM_LINES];
  logic [TAG_W-1:0]  tag_arr [NUM_LINES];
  logic [LINE_W-1:0] dat_arr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mesi_state_e       st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] dat_q;
    logic              fsm_sel, sp_sel;
    assign fsm_sel = fsm_we_i && (rd_idx_i == IDX_W'(g));
    assign sp_sel  = sp_we_i && (sp_idx_i == IDX_W'(g));

    // core-side update wins: its bus transaction was ordered after the snoop
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= ST_I;
        tag_q <= '0;
        dat_q <= '0;
      end else if (fsm_sel) begin
        st_q  <= fsm_state_i;
        tag_q <= fsm_tag_i;
        dat_q <= fsm_data_i;
      end else if (sp_sel) begin
        st_q  <= sp_state_i;
      end
    end
    assign st_arr[g]  = st_q;
    assign tag_arr[g] = tag_q;
    assign dat_arr[g] = dat_q;
  end

  assign rd_state_o = st_arr[rd_idx_i];
  assign rd_tag_o   = tag_arr[rd_idx_i];
  assign rd_data_o  = dat_arr[rd_idx_i];
  assign sp_state_o = st_arr[sp_idx_i];
  assign sp_tag_o   = tag_arr[sp_idx_i];
  assign sp_data_o  = dat_arr[sp_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             snp_valid_i,
  input  bus_cmd_e         snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  mesi_state_e      line_state_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             hit_o,
  output logic             flush_o,
  output mesi_state_e      next_state_o
);
  always_comb begin
    hit_o = snp_valid_i && (snp_cmd_i != BUS_WB) &&
            (line_state_i != ST_I) && (line_tag_i == snp_tag_i);
    flush_o = hit_o && (line_state_i == ST_M);
    next_state_o = (snp_cmd_i == BUS_RD) ? ST_S : ST_I;
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int OFF_W      = 2,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  core_op_e                     req_op_i,
  input  logic [TAG_W-1:0]             req_tag_i,
  input  logic [OFF_W-1:0]             req_off_i,
  input  logic [WORD_W-1:0]            req_wdata_i,
  input  logic [WORD_W*LINE_WORDS-1:0] req_wline_i,
  output logic                         req_ready_o,
  output logic [WORD_W-1:0]            rsp_rdata_o,
  input  mesi_state_e                  line_state_i,
  input  logic [TAG_W-1:0]             line_tag_i,
  input  logic [WORD_W*LINE_WORDS-1:0] line_data_i,
  output logic                         we_o,
  output mesi_state_e                  wr_state_o,
  output logic [WORD_W*LINE_WORDS-1:0] wr_data_o,
  output logic                         bus_req_o,
  output bus_cmd_e                     bus_cmd_o,
  output logic [TAG_W-1:0]             bus_tag_o,
  output logic [WORD_W*LINE_WORDS-1:0] bus_wdata_o,
  input  logic                         bus_ack_i,
  input  logic                         bus_shared_i,
  input  logic [WORD_W*LINE_WORDS-1:0] bus_rdata_i
);
  localparam int LINE_W = WORD_W * LINE_WORDS;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_BUS, F_RESP} fsm_e;

  fsm_e              state_q;
  bus_cmd_e          cmd_q, cmd_d;
  logic [WORD_W-1:0] rdata_q;
  logic              hit, need_bus, victim_dirty, local_go, bus_done;
  mesi_state_e       cur;
  logic [LINE_W-1:0] base, merged;

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[o*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  always_comb begin
    hit = (line_state_i != ST_I) && (line_tag_i == req_tag_i);
    cur = hit ? line_state_i : ST_I;
    victim_dirty = !hit && (line_state_i == ST_M);
    need_bus = 1'b0;
    cmd_d    = BUS_RD;
    unique case (req_op_i)
      OP_LOAD: begin
        need_bus = (cur == ST_I);
        cmd_d    = BUS_RD;
      end
      OP_STORE: begin
        need_bus = (cur == ST_I) || (cur == ST_S);
        cmd_d    = (cur == ST_S) ? BUS_INV : BUS_RDX;
      end
      OP_LDEX: begin
        need_bus = (cur == ST_I) || (cur == ST_S);
        cmd_d    = BUS_RDX;
      end
      OP_FULLWR: begin
        need_bus = (cur == ST_I) || (cur == ST_S);
        cmd_d    = BUS_INV;
      end
      default: ;
    endcase
  end

  // one merge path serves local hits and bus completions
  always_comb begin
    base = (state_q == F_BUS && cmd_q != BUS_INV) ? bus_rdata_i : line_data_i;
    if (req_op_i == OP_FULLWR)     merged = req_wline_i;
    else if (req_op_i == OP_STORE) merged = put_word(base, req_off_i, req_wdata_i);
    else                           merged = base;
  end

  assign local_go = (state_q == F_IDLE) && req_valid_i && !need_bus;
  assign bus_done = (state_q == F_BUS) && bus_ack_i;

  always_comb begin
    if (state_q == F_BUS) begin
      if (req_op_i == OP_LOAD)      wr_state_o = bus_shared_i ? ST_S : ST_E;
      else if (req_op_i == OP_LDEX) wr_state_o = ST_E;
      else                          wr_state_o = ST_M;
    end else begin
      wr_state_o = (req_op_i == OP_LOAD || req_op_i == OP_LDEX) ? cur : ST_M;
    end
  end

  assign we_o        = local_go || bus_done;
  assign wr_data_o   = merged;
  assign bus_req_o   = (state_q == F_WB) || (state_q == F_BUS);
  assign bus_cmd_o   = (state_q == F_WB) ? BUS_WB : cmd_q;
  assign bus_tag_o   = (state_q == F_WB) ? line_tag_i : req_tag_i;
  assign bus_wdata_o = (state_q == F_WB) ? line_data_i : '0;
  assign req_ready_o = (state_q == F_RESP);
  assign rsp_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      cmd_q   <= BUS_RD;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        F_IDLE: if (req_valid_i) begin
          if (!need_bus) begin
            rdata_q <= merged[req_off_i*WORD_W +: WORD_W];
            state_q <= F_RESP;
          end else begin
            cmd_q   <= cmd_d;
            state_q <= victim_dirty ? F_WB : F_BUS;
          end
        end
        F_WB:  if (bus_ack_i) state_q <= F_BUS;
        F_BUS: if (bus_ack_i) begin
          rdata_q <= merged[req_off_i*WORD_W +: WORD_W];
          state_q <= F_RESP;
        end
        F_RESP: state_q <= F_IDLE;
        default: state_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 16,
  localparam int IDX_W   = $clog2(NUM_LINES),
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W  = WORD_W * LINE_WORDS,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0]  req_wdata_i,
  input  logic [LINE_W-1:0]  req_wline_i,
  output logic [WORD_W-1:0]  rsp_rdata_o,
  output logic               bus_req_o,
  output logic [1:0]         bus_cmd_o,
  output logic [LADDR_W-1:0] bus_addr_o,
  output logic [LINE_W-1:0]  bus_wdata_o,
  input  logic               bus_ack_i,
  input  logic               bus_shared_i,
  input  logic [LINE_W-1:0]  bus_rdata_i,
  input  logic               snp_valid_i,
  input  logic [1:0]         snp_cmd_i,
  input  logic [LADDR_W-1:0] snp_addr_i,
  output logic               snp_shared_o,
  output logic               snp_flush_o,
  output logic [LINE_W-1:0]  snp_data_o
);
  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx, sp_idx;
  logic [TAG_W-1:0]  req_tag, sp_tag, rd_tag, sl_tag, bus_tag;
  mesi_state_e       rd_state, sl_state, wr_state, sp_next;
  logic [LINE_W-1:0] rd_data, wr_data;
  logic              fsm_we, sp_hit;
  bus_cmd_e          bus_cmd;

  assign req_off = req_addr_i[OFF_W-1:0];
  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign sp_idx  = snp_addr_i[IDX_W-1:0];
  assign sp_tag  = snp_addr_i[LADDR_W-1 -: TAG_W];

  mesi_line_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (req_idx),
    .sp_idx_i   (sp_idx),
    .fsm_we_i   (fsm_we),
    .fsm_state_i(wr_state),
    .fsm_tag_i  (req_tag),
    .fsm_data_i (wr_data),
    .sp_we_i    (sp_hit),
    .sp_state_i (sp_next),
    .rd_state_o (rd_state),
    .rd_tag_o   (rd_tag),
    .rd_data_o  (rd_data),
    .sp_state_o (sl_state),
    .sp_tag_o   (sl_tag),
    .sp_data_o  (snp_data_o)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i   (sp_tag),
    .line_state_i(sl_state),
    .line_tag_i  (sl_tag),
    .hit_o       (sp_hit),
    .flush_o     (snp_flush_o),
    .next_state_o(sp_next)
  );

  mesi_req_fsm #(
    .TAG_W(TAG_W), .OFF_W(OFF_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (core_op_e'(req_op_i)),
    .req_tag_i   (req_tag),
    .req_off_i   (req_off),
    .req_wdata_i (req_wdata_i),
    .req_wline_i (req_wline_i),
    .req_ready_o (req_ready_o),
    .rsp_rdata_o (rsp_rdata_o),
    .line_state_i(rd_state),
    .line_tag_i  (rd_tag),
    .line_data_i (rd_data),
    .we_o        (fsm_we),
    .wr_state_o  (wr_state),
    .wr_data_o   (wr_data),
    .bus_req_o   (bus_req_o),
    .bus_cmd_o   (bus_cmd),
    .bus_tag_o   (bus_tag),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_shared_i(bus_shared_i),
    .bus_rdata_i (bus_rdata_i)
  );

  assign bus_cmd_o    = bus_cmd;
  assign bus_addr_o   = {bus_tag, req_idx};
  assign snp_shared_o = sp_hit;
endmodule

// File: rtl/mesi_cache_ctrl_chk.sv
module mesi_cache_ctrl_chk #(
  parameter int LADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_ready_o,
  input logic               bus_req_o,
  input logic [1:0]         bus_cmd_o,
  input logic [LADDR_W-1:0] bus_addr_o,
  input logic               bus_ack_i,
  input logic               snp_valid_i,
  input logic [1:0]         snp_cmd_i,
  input logic               snp_shared_o,
  input logic               snp_flush_o
);
  a_r10_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o));

  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  a_r10_ready_after_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_req_o);

  a_r9_wb_then_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_cmd_o == 2'b00 |=> bus_req_o && bus_cmd_o != 2'b00);

  a_r7_flush_implies_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_shared_o);

  a_r7_wb_snoop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i || snp_cmd_i == 2'b00 |-> !snp_shared_o && !snp_flush_o);
endmodule

bind mesi_cache_ctrl mesi_cache_ctrl_chk #(.LADDR_W(LADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_cmd_o   (bus_cmd_o),
  .bus_addr_o  (bus_addr_o),
  .bus_ack_i   (bus_ack_i),
  .snp_valid_i (snp_valid_i),
  .snp_cmd_i   (snp_cmd_i),
  .snp_shared_o(snp_shared_o),
  .snp_flush_o (snp_flush_o)
);

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;
  localparam int NL = 4, LW = 4, WW = 16, AW = 8;
  localparam int LINE_W = WW * LW, LAW = AW - 2;
  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
  localparam logic [1:0] WB = 2'd0, RD = 2'd1, RDX = 2'd2, INV = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [WW-1:0] req_wdata = '0, rsp_rdata;
  logic [LINE_W-1:0] req_wline = '0;
  logic bus_req, bus_ack = 1'b0, bus_shared = 1'b0;
  logic [1:0] bus_cmd;
  logic [LAW-1:0] bus_addr;
  logic [LINE_W-1:0] bus_wdata, bus_rdata = '0;
  logic snp_valid = 1'b0, snp_shared, snp_flush;
  logic [1:0] snp_cmd = '0;
  logic [LAW-1:0] snp_addr = '0;
  logic [LINE_W-1:0] snp_data;

  always #2 clk = ~clk;

  mesi_cache_ctrl #(.NUM_LINES(NL), .LINE_WORDS(LW), .WORD_W(WW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_wline_i(req_wline),
    .rsp_rdata_o(rsp_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_shared_i(bus_shared),
    .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_data_o(snp_data)
  );

  int n_chk = 0, n_err = 0;
  logic [1:0]        m_st  [NL];
  logic [3:0]        m_tag [NL];
  logic [LINE_W-1:0] m_dat [NL];

  task automatic check(input bit ok, input string r, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] rnd_line();
    return {$urandom, $urandom};
  endfunction

  // one core request with an in-task bus responder; model-predicted transactions
  task automatic do_req(input logic [1:0] op, input logic [AW-1:0] addr, input logic [WW-1:0] w,
                        input logic [LINE_W-1:0] wl, input bit shr, input string r);
    logic [1:0] idx, st, nst, cmd;
    logic [3:0] tg;
    logic [1:0] off;
    logic [LINE_W-1:0] rl, base, nd;
    bit hit, need, exp_wb, done;
    int nbus, nexp;
    idx = addr[3:2]; tg = addr[7:4]; off = addr[1:0];
    hit = (m_st[idx] != I) && (m_tag[idx] == tg);
    st = hit ? m_st[idx] : I;
    need = (op == 2'd0) ? (st == I) : (st == I || st == S);
    cmd = (op == 2'd0) ? RD : (op == 2'd2) ? RDX : (op == 2'd3) ? INV : (st == S ? INV : RDX);
    exp_wb = need && !hit && (m_st[idx] == M);
    rl = rnd_line();
    base = (need && cmd != INV) ? rl : m_dat[idx];
    nd = base;
    if (op == 2'd3) nd = wl;
    else if (op == 2'd1) nd[off*WW +: WW] = w;
    if (need) nst = (op == 2'd0) ? (shr ? S : E) : (op == 2'd2) ? E : M;
    else      nst = (op == 2'd1 || op == 2'd3) ? M : st;
    nexp = int'(need) + int'(exp_wb);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = w; req_wline = wl;
    nbus = 0; done = 1'b0;
    for (int c = 0; c < 100 && !done; c++) begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (req_ready) begin
        check(rsp_rdata == nd[off*WW +: WW], {r, " rdata"}, LINE_W'(rsp_rdata), LINE_W'(nd[off*WW +: WW]));
        check(nbus == nexp, {r, " R10 bus count"}, LINE_W'(nbus), LINE_W'(nexp));
        req_valid = 1'b0;
        done = 1'b1;
      end else if (bus_req) begin
        nbus++;
        if (nbus == 1 && exp_wb) begin
          check(bus_cmd == WB && bus_addr == {m_tag[idx], idx}, "R9 writeback cmd/addr",
                LINE_W'({bus_cmd, bus_addr}), LINE_W'({WB, m_tag[idx], idx}));
          check(bus_wdata == m_dat[idx], "R9 writeback data", bus_wdata, m_dat[idx]);
        end else begin
          check(bus_cmd == cmd && bus_addr == {tg, idx}, {r, " bus cmd/addr"},
                LINE_W'({bus_cmd, bus_addr}), LINE_W'({cmd, tg, idx}));
        end
        repeat ($urandom % 3) @(negedge clk);
        check(req_ready == 1'b0 && bus_req, "R10 hold until ack", LINE_W'({req_ready, bus_req}), LINE_W'(2'b01));
        bus_ack = 1'b1; bus_shared = shr; bus_rdata = rl;
      end
    end
    if (!done) begin
      check(1'b0, {r, " R10 request never completed"}, '0, '1);
      req_valid = 1'b0;
    end
    if (need || op != 2'd0 || hit) begin
      m_st[idx] = nst; m_tag[idx] = tg; m_dat[idx] = nd;
    end
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input logic [LAW-1:0] la, input string r);
    logic [1:0] idx;
    bit hit, exp_sh, exp_fl;
    idx = la[1:0];
    hit = (m_st[idx] != I) && (m_tag[idx] == la[5:2]);
    exp_sh = hit && (cmd != WB);
    exp_fl = exp_sh && (m_st[idx] == M);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = la;
    #1;
    check(snp_shared == exp_sh, {r, " snoop shared"}, LINE_W'(snp_shared), LINE_W'(exp_sh));
    check(snp_flush == exp_fl, {r, " snoop flush"}, LINE_W'(snp_flush), LINE_W'(exp_fl));
    if (exp_fl) check(snp_data == m_dat[idx], {r, " flush data"}, snp_data, m_dat[idx]);
    @(negedge clk);
    snp_valid = 1'b0;
    if (exp_sh) m_st[idx] = (cmd == RD) ? S : I;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] fl;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NL; i++) begin m_st[i] = I; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_ready && !bus_req, "R1 idle after reset", LINE_W'({req_ready, bus_req}), '0);
    for (int i = 0; i < NL; i++) do_snoop(RD, LAW'(i), "R1");
    // R2 miss into E, R3 silent E->M store, R6 flush on M, R4 upgrade from S
    do_req(2'd0, 8'h11, '0, '0, 1'b0, "R2 load miss E");
    do_req(2'd1, 8'h12, 16'hbeef, '0, 1'b0, "R3 store on E");
    do_snoop(RD, 6'h04, "R6 read snoop on M");
    do_req(2'd1, 8'h13, 16'h1234, '0, 1'b0, "R4 store on S");
    // R2 shared response gives S
    do_req(2'd0, 8'h24, '0, '0, 1'b1, "R2 load miss S");
    do_req(2'd1, 8'h25, 16'h0f0f, '0, 1'b0, "R4 upgrade");
    do_req(2'd1, 8'h38, 16'h5555, '0, 1'b1, "R4 store miss");
    // R5 load-exclusive ignores shared, then store stays local
    do_req(2'd2, 8'h4c, '0, '0, 1'b1, "R5 ldex miss");
    do_req(2'd1, 8'h4d, 16'haaaa, '0, 1'b0, "R5 store after ldex");
    do_req(2'd2, 8'h5c, '0, '0, 1'b0, "R5 ldex evicts M");
    do_snoop(RD, 6'h17, "R6 read snoop on E");
    do_req(2'd1, 8'h5e, 16'h7777, '0, 1'b0, "R6 store after E->S");
    // R8 full write on M victim: writeback then invalidate
    fl = rnd_line();
    do_req(2'd3, 8'h60, '0, fl, 1'b1, "R8 full write miss");
    do_req(2'd0, 8'h63, '0, '0, 1'b0, "R8 load after full write");
    do_snoop(RDX, 6'h18, "R7 rdx snoop on M");
    do_req(2'd0, 8'h61, '0, '0, 1'b0, "R7 reload after invalidate");
    do_snoop(INV, 6'h18, "R7 inv snoop on E");
    do_snoop(WB, 6'h09, "R7 wb snoop ignored");
    do_req(2'd1, 8'h26, 16'h4242, '0, 1'b0, "R7 line kept after wb snoop");
    // R9 silent eviction of E and S
    do_req(2'd0, 8'h70, '0, '0, 1'b0, "R9 load E");
    do_req(2'd0, 8'h80, '0, '0, 1'b1, "R9 evict E silent");
    do_req(2'd0, 8'h90, '0, '0, 1'b0, "R9 evict S silent");
    // random mix over three aliasing tags
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      a = {4'($urandom % 3), 4'($urandom)};
      if ($urandom % 4 == 0)
        do_snoop(2'($urandom), {4'($urandom % 3), 2'($urandom)}, "R7 random snoop");
      op = 2'($urandom);
      case (op)
        2'd0: do_req(op, a, '0, '0, 1'($urandom), "R2 random load");
        2'd1: do_req(op, a, 16'($urandom), '0, 1'($urandom), "R4 random store");
        2'd2: do_req(op, a, '0, '0, 1'($urandom), "R5 random ldex");
        default: do_req(op, a, '0, rnd_line(), 1'($urandom), "R8 random full write");
      endcase
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule